// File: doc/BRIEF.md
# Oscillator-halt and brownout status flags

This block holds the health flags of a real-time-clock register set. It watches the 32.768 kHz oscillator from a faster free-running sampling clock. When the synchronized oscillator input shows no edge for longer than a programmable number of sampling cycles, the block declares a halt. It also takes the digital output of a low-supply comparator and keeps two sticky flags: one for a stopped oscillator and one for a dropped supply.

A halt sets the oscillator-stopped flag and forces the supply-dropped flag to zero. A halt also clears a group of configuration and status bits: the trim field, the alarm and clock-output enables, the 12/24-hour select, the test bit, the periodic-interrupt select, the threshold select, the scratch bit and the three event flags. Power-on reset leaves the oscillator-stopped flag set. For a set number of oscillator cycles after reset the supply flag ignores the comparator, which models the start-up settling period.

Software reads three registers through a combinational read port and clears flags by writing zero to them. The threshold-select bit is passed through to the comparator.

Top module: `rtc_health_flags`

## Requirements
- R1: After reset, STAT (address 2) reads 0x80, and TRIM (address 0) and CONF (address 1) both read 0x00.
- R2: If edges of the synchronized oscillator input are spaced g sampling cycles apart, STAT bit 7 (oscillator stopped) is set exactly when g > HALT_CYCLES. A stopped oscillator sets this bit after a bounded delay.
- R3: A halt forces STAT bit 6 (supply dropped) to 0.
- R4: A halt clears TRIM[6:0], all of CONF[7:0] and STAT[5:0], and a software write in the same cycle does not override this.
- R5: STAT bits 7..3 are sticky. Writing 0 to one of these bits clears it, and writing 1 leaves it unchanged.
- R6: If a set condition occurs in the same cycle as a software clear of the same flag, the flag ends at 1.
- R7: STAT bit 6 latches 1 on a synchronized high of vlow_i. It does not latch until INIT_TICKS rising oscillator edges have been counted since reset.
- R8: TRIM[6:0], CONF[7:0] and STAT[2:0] are writable and read back. TRIM bit 7 and address 3 read 0. thr_sel_o equals STAT bit 1. Reads have no side effects.
- R9: Pulses on evt_prd_i, evt_wk_i and evt_dy_i set STAT bits 3, 4 and 5 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low power-on reset |
| osc_i | input | 1 | 32.768 kHz oscillator, asynchronous |
| vlow_i | input | 1 | Low-supply comparator output, asynchronous |
| evt_prd_i | input | 1 | Periodic-interrupt event pulse |
| evt_wk_i | input | 1 | Weekly-alarm match pulse |
| evt_dy_i | input | 1 | Daily-alarm match pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| thr_sel_o | output | 1 | Threshold select to the comparator |
| osc_stop_o | output | 1 | Oscillator-stopped flag |
| supply_drop_o | output | 1 | Supply-dropped flag |

## Verification
The bench sweeps the oscillator edge spacing across the halt limit. A timeout counter that is off by one would flag a halt one spacing early or one spacing late. It drives a comparator pulse during the start-up window, which catches a design that latches the supply flag too early. It also collides clears with set conditions (halt, comparator and events) and checks that the set wins; a design that lets the clear win would lose real events. Finally, it stops the oscillator after filling every register and confirms the exact group of bits that is cleared. This exposes a design that leaves a bit out of the group, clears a bit outside it, or lets the supply flag survive the halt.

// File: rtl/rtc_flags_pkg.sv
package rtc_flags_pkg;
  localparam int AW = 2;
  localparam int DW = 8;
  localparam logic [AW-1:0] ADDR_TRIM = 2'd0;
  localparam logic [AW-1:0] ADDR_CONF = 2'd1;
  localparam logic [AW-1:0] ADDR_STAT = 2'd2;
  localparam int B_STOP = 7;
  localparam int B_DROP = 6;
  localparam int B_DY   = 5;
  localparam int B_WK   = 4;
  localparam int B_PRD  = 3;
  localparam int B_THR  = 1;
endpackage

// File: rtl/rtcf_osc_watch.sv
module rtcf_osc_watch #(
  parameter int HALT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_i,
  output logic halt_o,
  output logic rise_o
);
  localparam int CW = $clog2(HALT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HALT_CYCLES);

  logic [2:0] sync_q;
  logic [CW-1:0] gap_q;
  logic edge_w;

  assign edge_w = sync_q[1] ^ sync_q[2];
  assign rise_o = sync_q[1] & ~sync_q[2];
  assign halt_o = (gap_q == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      gap_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], osc_i};
      if (edge_w)
        gap_q <= '0;
      else if (gap_q != LIMIT)
        gap_q <= gap_q + 1'b1;
    end
  end

  // R2
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= LIMIT);
  // R2
  gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> (gap_q == '0));
endmodule

// File: rtl/rtcf_supply_mon.sv
module rtcf_supply_mon #(
  parameter int INIT_TICKS = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vlow_i,
  input  logic osc_rise_i,
  output logic low_o,
  output logic ready_o
);
  localparam int IW = $clog2(INIT_TICKS + 1);
  localparam logic [IW-1:0] IEND = IW'(INIT_TICKS);

  logic [1:0] sync_q;
  logic [IW-1:0] tick_q;

  assign low_o   = sync_q[1];
  assign ready_o = (tick_q == IEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      tick_q <= '0;
    end else begin
      sync_q <= {sync_q[0], vlow_i};
      if (osc_rise_i && tick_q != IEND)
        tick_q <= tick_q + 1'b1;
    end
  end

  // R7
  init_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q <= IEND);
  // R7
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);
endmodule

// File: rtl/rtcf_reg_bank.sv
module rtcf_reg_bank
  import rtc_flags_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt_i,
  input  logic          low_i,
  input  logic          ready_i,
  input  logic          evt_prd_i,
  input  logic          evt_wk_i,
  input  logic          evt_dy_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          stop_o,
  output logic          drop_o,
  output logic          thr_o
);
  logic [6:0] trim_q;
  logic [7:0] conf_q;
  logic [2:0] cfg_lo_q;
  logic stop_q, drop_q;
  logic [2:0] evt_q;
  logic [2:0] evt_set;
  logic wr_trim, wr_conf, wr_stat;

  assign wr_trim = wr_en_i && wr_addr_i == ADDR_TRIM;
  assign wr_conf = wr_en_i && wr_addr_i == ADDR_CONF;
  assign wr_stat = wr_en_i && wr_addr_i == ADDR_STAT;
  assign evt_set = {evt_dy_i, evt_wk_i, evt_prd_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q   <= '0;
      conf_q   <= '0;
      cfg_lo_q <= '0;
      stop_q   <= 1'b1;
      drop_q   <= 1'b0;
      evt_q    <= '0;
    end else if (halt_i) begin
      trim_q   <= '0;
      conf_q   <= '0;
      cfg_lo_q <= '0;
      stop_q   <= 1'b1;
      drop_q   <= 1'b0;
      evt_q    <= '0;
    end else begin
      if (wr_trim) trim_q <= wr_data_i[6:0];
      if (wr_conf) conf_q <= wr_data_i;
      if (wr_stat) cfg_lo_q <= wr_data_i[2:0];
      if (wr_stat && !wr_data_i[B_STOP]) stop_q <= 1'b0;
      if (low_i && ready_i)
        drop_q <= 1'b1;
      else if (wr_stat && !wr_data_i[B_DROP])
        drop_q <= 1'b0;
      for (int i = 0; i < 3; i++) begin
        if (evt_set[i])
          evt_q[i] <= 1'b1;
        else if (wr_stat && !wr_data_i[B_PRD+i])
          evt_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      ADDR_TRIM: rd_data_o = {1'b0, trim_q};
      ADDR_CONF: rd_data_o = conf_q;
      ADDR_STAT: rd_data_o = {stop_q, drop_q, evt_q, cfg_lo_q};
      default:   rd_data_o = '0;
    endcase
  end

  assign stop_o = stop_q;
  assign drop_o = drop_q;
  assign thr_o  = cfg_lo_q[B_THR];

  // R2
  halt_sets_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> stop_q);
  // R3
  halt_drops_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> !drop_q);
  // R4
  halt_clears_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> (trim_q == '0 && conf_q == '0 && cfg_lo_q == '0 && evt_q == '0));
  // R5
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !(wr_stat && !wr_data_i[B_STOP])) |=> stop_q);
  // R7
  init_blocks_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_i && !drop_q) |=> !drop_q);
  // R6
  drop_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_i && ready_i && !halt_i) |=> drop_q);
endmodule

// File: rtl/rtc_health_flags.sv
module rtc_health_flags
  import rtc_flags_pkg::*;
#(
  parameter int HALT_CYCLES = 16,
  parameter int INIT_TICKS  = 32768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_i,
  input  logic          vlow_i,
  input  logic          evt_prd_i,
  input  logic          evt_wk_i,
  input  logic          evt_dy_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          thr_sel_o,
  output logic          osc_stop_o,
  output logic          supply_drop_o
);
  logic halt_w, rise_w, low_w, ready_w;

  rtcf_osc_watch #(.HALT_CYCLES(HALT_CYCLES)) u_watch (
    .clk(clk), .rst_n(rst_n), .osc_i(osc_i),
    .halt_o(halt_w), .rise_o(rise_w));

  rtcf_supply_mon #(.INIT_TICKS(INIT_TICKS)) u_supply (
    .clk(clk), .rst_n(rst_n), .vlow_i(vlow_i), .osc_rise_i(rise_w),
    .low_o(low_w), .ready_o(ready_w));

  rtcf_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_w), .low_i(low_w), .ready_i(ready_w),
    .evt_prd_i(evt_prd_i), .evt_wk_i(evt_wk_i), .evt_dy_i(evt_dy_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .stop_o(osc_stop_o), .drop_o(supply_drop_o), .thr_o(thr_sel_o));
endmodule

// File: tb/rtc_health_flags_bench.sv
`timescale 1ns/1ps
module rtc_health_flags_bench;
  localparam int HC = 8;
  localparam int IT = 4;

  logic clk = 0, rst_n = 0, osc = 0, vlow = 0;
  logic ep = 0, ew = 0, ed = 0, wr_en = 0;
  logic [1:0] wa = 0, ra = 0;
  logic [7:0] wd = 0, rd;
  logic thr, stop, drop;
  int half = 2;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_health_flags #(.HALT_CYCLES(HC), .INIT_TICKS(IT)) u_rtc_health_flags (
    .clk(clk), .rst_n(rst_n), .osc_i(osc), .vlow_i(vlow),
    .evt_prd_i(ep), .evt_wk_i(ew), .evt_dy_i(ed),
    .wr_en_i(wr_en), .wr_addr_i(wa), .wr_data_i(wd), .rd_addr_i(ra),
    .rd_data_o(rd), .thr_sel_o(thr), .osc_stop_o(stop), .supply_drop_o(drop));

  initial begin
    forever begin
      if (half == 0) @(posedge clk);
      else begin
        repeat (half) @(posedge clk);
        #1 osc = ~osc;
      end
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); ra = a; #0.5 v = rd;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wa = a; wd = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    vlow = 1;
    idle(3);
    rst_n = 1;
    // R1 reset state
    rd_reg(2'd2, v); check("R1 stat", v, 8'h80);
    rd_reg(2'd0, v); check("R1 trim", v, 8'h00);
    rd_reg(2'd1, v); check("R1 conf", v, 8'h00);
    idle(3); vlow = 0;
    idle(30);
    // R7 comparator pulse during init window ignored
    rd_reg(2'd2, v); check("R7 init window", v & 8'h40, 8'h00);
    vlow = 1; idle(4); vlow = 0; idle(4);
    rd_reg(2'd2, v); check("R7 latch after init", v & 8'h40, 8'h40);
    // R5 clear by writing 0
    wr_reg(2'd2, 8'h00); idle(2);
    rd_reg(2'd2, v); check("R5 clear", v, 8'h00);
    check("R5 port flags", {6'd0, stop, drop}, 8'h00);
    wr_reg(2'd2, 8'hF8); idle(2);
    rd_reg(2'd2, v); check("R5 write 1 no effect", v, 8'h00);
    // R9 events
    @(negedge clk); ep = 1; @(negedge clk); ep = 0;
    rd_reg(2'd2, v); check("R9 periodic", v, 8'h08);
    @(negedge clk); ew = 1; ed = 1; @(negedge clk); ew = 0; ed = 0;
    rd_reg(2'd2, v); check("R9 alarms", v, 8'h38);
    wr_reg(2'd2, 8'hE0); idle(1);
    rd_reg(2'd2, v); check("R5 selective clear", v, 8'h20);
    // R6 event set collides with clear
    @(negedge clk); wr_en = 1; wa = 2'd2; wd = 8'h00; ep = 1;
    @(negedge clk); wr_en = 0; ep = 0;
    rd_reg(2'd2, v); check("R6 event set wins", v, 8'h08);
    // R6 comparator held high while clearing
    vlow = 1; idle(4); wr_reg(2'd2, 8'h00); idle(1);
    rd_reg(2'd2, v); check("R6 supply set wins", v, 8'h40);
    vlow = 0; idle(4); wr_reg(2'd2, 8'h00); idle(1);
    // R8 read/write
    wr_reg(2'd0, 8'hFF); rd_reg(2'd0, v); check("R8 trim", v, 8'h7F);
    wr_reg(2'd1, 8'hA5); rd_reg(2'd1, v); check("R8 conf", v, 8'hA5);
    wr_reg(2'd2, 8'h02); rd_reg(2'd2, v); check("R8 stat low", v, 8'h02);
    check("R8 thr_sel", {7'd0, thr}, 8'h01);
    wr_reg(2'd2, 8'h05); rd_reg(2'd2, v); check("R8 stat low 2", v, 8'h05);
    check("R8 thr_sel low", {7'd0, thr}, 8'h00);
    rd_reg(2'd3, v); check("R8 addr3", v, 8'h00);
    rd_reg(2'd1, v); rd_reg(2'd1, v2); check("R8 read no side effect", v2, v);
    // R3/R4 halt clears group
    wr_reg(2'd2, 8'h07); wr_reg(2'd1, 8'hFF);
    @(negedge clk); ep = 1; ew = 1; ed = 1; @(negedge clk); ep = 0; ew = 0; ed = 0;
    vlow = 1; idle(4); vlow = 0;
    rd_reg(2'd2, v); check("R4 pre-halt stat", v, 8'h7F);
    half = 0; idle(3 * HC);
    rd_reg(2'd2, v); check("R2/R3/R4 stat after halt", v, 8'h80);
    rd_reg(2'd0, v); check("R4 trim after halt", v, 8'h00);
    rd_reg(2'd1, v); check("R4 conf after halt", v, 8'h00);
    // R4/R6 write and clear during halt are overridden
    wr_reg(2'd1, 8'h3C); wr_reg(2'd2, 8'h07); idle(1);
    rd_reg(2'd1, v); check("R4 conf write during halt", v, 8'h00);
    rd_reg(2'd2, v); check("R6 halt set wins", v, 8'h80);
    // R2 sweep of edge spacing
    for (int g = 2; g <= 14; g++) begin
      half = g;
      idle(4 * g + 10);
      wr_reg(2'd2, 8'h00);
      idle(6 * g + 10);
      rd_reg(2'd2, v);
      check($sformatf("R2 spacing %0d", g), v & 8'h80, (g > HC) ? 8'h80 : 8'h00);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule